// File: doc/BRIEF.md
# Block-Gated Stream-to-Host Egress Buffer

This block sits between a producer that streams words with a valid/ready handshake and a host port that reads data one 16-bit word per strobe. Stream words are collected in an internal FIFO. The host may start a block read only when a full block is waiting. The host sets the block length through a 16-bit register, in bytes. A host that starts reading a block therefore never stalls partway through it.

A width parameter sets the stream word to 16 or 32 bits. In 32-bit mode each buffered stream word is returned as two host words. The upper half comes out first. The block is cleared by a global reset, which is active while the host trigger bit is set or the clock-lock status is low.

The FIFO uses registered reads, not fall-through. Each host strobe that pops a word places that word on the host data output at the next clock edge. Fill levels and block lengths are counted in 16-bit host words.

Top module: `egress_bridge`

## Requirements
- R1: While the global reset is active (host trigger high or clock lock low), and on the first cycle after it is released, the host ready flag is low, the stream ready output is high (FIFO empty) and the host data output is zero.
- R2: A stream word is accepted only in a cycle where stream valid and stream ready are both high. Stream ready is low whenever accepting one more stream word would exceed the FIFO capacity of DEPTH_HW host words. It stays low until the host pops a word.
- R3: The block length in host words is the programmed byte count shifted right by one bit. When the length is zero (byte count 0 or 1), the host ready flag is never raised.
- R4: A programmed byte count above the 1024-byte maximum is treated as 1024 bytes, which is 512 host words.
- R5: Outside a block read, host ready is high exactly when the buffered host-word count is at least the block length. A strobe while ready is high starts a block. For a block of two or more words, ready is low from the next cycle until that block's last word has been popped. After that, ready is evaluated again.
- R6: Each popped word appears on the host data output one cycle after its strobe, in FIFO order. The output holds its value in cycles with no pop.
- R7: With 32-bit stream words, bits 31:16 of a stream word are returned before bits 15:0.
- R8: A strobe that arrives while no block read is in progress and host ready is low is ignored: no word is popped and the data output does not change.
- R9: The block length is sampled when a block read starts. Changing the byte count during a block does not change how many words that block pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hostTrig | input | 1 | Host reset trigger, active high |
| clkLocked | input | 1 | Clock-lock status; low holds the block in reset |
| streamData | input | STREAM_W | Producer stream word |
| streamValid | input | 1 | Producer has a word |
| streamReady | output | 1 | FIFO can take a stream word |
| blockBytes | input | 16 | Host-programmed block length in bytes |
| hostRdStrobe | input | 1 | Host read strobe, one word per cycle |
| hostData | output | 16 | Popped host word, valid the cycle after the strobe |
| hostReady | output | 1 | A full block is buffered and may be read |

## Verification
The hardest cases to reach are the FIFO's full boundary and the mid-block change of block length. The full boundary is a different count in 32-bit and 16-bit mode.

To reach the full boundary, the bench holds stream valid high for more than a thousand cycles with no host reads. It then drains one maximum-size block and checks that stream ready returns.

To cover the mid-block case, the bench changes the byte count while a block is being read. The byte counts used are zero, one, values above the maximum, and small even sizes. Two instances, one per stream width, run the same stimulus against a behavioural queue model for each width.

// File: rtl/egress_pkg.sv
package egress_pkg;
  localparam int HOST_W = 16;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic push;  // write one stream word
    logic pop;   // read one host word
  } egress_ctl_t;
endpackage

// File: rtl/egress_ctrl.sv
module egress_ctrl
  import egress_pkg::*;
#(
  parameter int RATIO     = 2,
  parameter int DEPTH_HW  = 1024,
  parameter int MAX_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        streamValid,
  input  logic        hostRdStrobe,
  input  logic [15:0] blockBytes,
  output logic        streamReady,
  output logic        hostReady,
  output egress_ctl_t ctl
);
  localparam int MAX_WORDS = MAX_BYTES / 2;
  localparam int CNT_W     = $clog2(DEPTH_HW + 1);
  localparam int BW_W      = $clog2(MAX_WORDS + 1);
  localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(DEPTH_HW - RATIO);
  localparam logic [CNT_W-1:0] RATIO_C  = CNT_W'(RATIO);

  logic [CNT_W-1:0] fillWords;
  logic [BW_W-1:0]  blockWords;
  logic [BW_W-1:0]  remain;
  logic             inBurst;
  logic [15:0]      clampBytes;
  logic             enough;

  // Byte count to word count, clamped to the maximum block
  always_comb begin
    clampBytes = (blockBytes > 16'(MAX_BYTES)) ? 16'(MAX_BYTES) : blockBytes;
    blockWords = BW_W'(clampBytes >> 1);
  end

  // Fill-side process: stream acceptance
  assign streamReady = (fillWords <= FULL_LIM);
  assign ctl.push    = streamValid && streamReady;

  // Host-side process: block gating
  assign enough    = (blockWords != '0) && (fillWords >= CNT_W'(blockWords));
  assign hostReady = !inBurst && enough;
  assign ctl.pop   = hostRdStrobe && (inBurst || hostReady);

  always_ff @(posedge clk) begin
    if (rst) begin
      fillWords <= '0;
    end else begin
      fillWords <= fillWords + (ctl.push ? RATIO_C : '0) - (ctl.pop ? CNT_W'(1) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inBurst <= 1'b0;
      remain  <= '0;
    end else if (ctl.pop) begin
      if (!inBurst) begin
        remain  <= blockWords - BW_W'(1);
        inBurst <= (blockWords > BW_W'(1));
      end else begin
        remain  <= remain - BW_W'(1);
        inBurst <= (remain > BW_W'(1));
      end
    end
  end
endmodule

// File: rtl/egress_datapath.sv
module egress_datapath
  import egress_pkg::*;
#(
  parameter int STREAM_W = 32,
  parameter int RATIO    = 2,
  parameter int DEPTH_HW = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  egress_ctl_t         ctl,
  input  logic [STREAM_W-1:0] streamData,
  output logic [HOST_W-1:0]   hostData
);
  localparam int ENTRIES = DEPTH_HW / RATIO;
  localparam int AW      = $clog2(ENTRIES);
  localparam int HPW     = $clog2(DEPTH_HW);

  logic [STREAM_W-1:0] mem [ENTRIES];
  logic [AW-1:0]       wrPtr;
  logic [HPW-1:0]      rdPtr;   // counts host words
  logic [STREAM_W-1:0] rdWord;
  logic [HOST_W-1:0]   rdLane;

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= streamData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + AW'(1);
      if (ctl.pop)  rdPtr <= rdPtr + HPW'(1);
    end
  end

  generate
    if (RATIO == 1) begin : g_narrow
      assign rdWord = mem[rdPtr];
      assign rdLane = rdWord[HOST_W-1:0];
    end else begin : g_wide
      localparam int SEL_W = $clog2(RATIO);
      logic [SEL_W-1:0] sel;
      assign sel    = rdPtr[SEL_W-1:0];
      assign rdWord = mem[rdPtr[HPW-1:SEL_W]];
      // Most significant lane leaves first
      assign rdLane = rdWord[(RATIO-1-int'(sel))*HOST_W +: HOST_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          hostData <= '0;
    else if (ctl.pop) hostData <= rdLane;
  end
endmodule

// File: rtl/egress_bridge.sv
module egress_bridge
  import egress_pkg::*;
#(
  parameter int STREAM_W  = 32,
  parameter int DEPTH_HW  = 1024,
  parameter int MAX_BYTES = 1024
) (
  input  logic                clk,
  input  logic                hostTrig,
  input  logic                clkLocked,
  input  logic [STREAM_W-1:0] streamData,
  input  logic                streamValid,
  output logic                streamReady,
  input  logic [15:0]         blockBytes,
  input  logic                hostRdStrobe,
  output logic [15:0]         hostData,
  output logic                hostReady
);
  localparam int RATIO = STREAM_W / HOST_W;

  logic        rstG;
  egress_ctl_t ctlS;

  assign rstG = hostTrig | ~clkLocked;

  egress_ctrl #(
    .RATIO(RATIO), .DEPTH_HW(DEPTH_HW), .MAX_BYTES(MAX_BYTES)
  ) ctrl_i (
    .clk(clk), .rst(rstG), .streamValid(streamValid),
    .hostRdStrobe(hostRdStrobe), .blockBytes(blockBytes),
    .streamReady(streamReady), .hostReady(hostReady), .ctl(ctlS)
  );

  egress_datapath #(
    .STREAM_W(STREAM_W), .RATIO(RATIO), .DEPTH_HW(DEPTH_HW)
  ) dp_i (
    .clk(clk), .rst(rstG), .ctl(ctlS),
    .streamData(streamData), .hostData(hostData)
  );
endmodule

// File: rtl/egress_bridge_chk.sv
module egress_bridge_chk (
  input logic        clk,
  input logic        hostTrig,
  input logic        clkLocked,
  input logic        streamReady,
  input logic [15:0] blockBytes,
  input logic        hostRdStrobe,
  input logic [15:0] hostData,
  input logic        hostReady
);
  logic rstC;
  assign rstC = hostTrig | ~clkLocked;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rstC |=> (!hostReady && streamReady && hostData == 16'h0));

  // R3
  zero_block_chk: assert property (@(posedge clk) disable iff (rstC)
    (blockBytes < 16'd2) |-> !hostReady);

  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (rstC)
    (hostReady && hostRdStrobe && blockBytes >= 16'd4) |=> !hostReady);

  // R2
  stay_full_chk: assert property (@(posedge clk) disable iff (rstC)
    (!streamReady && !hostRdStrobe) |=> !streamReady);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rstC)
    !hostRdStrobe |=> $stable(hostData));
endmodule

bind egress_bridge egress_bridge_chk chk_i (
  .clk(clk), .hostTrig(hostTrig), .clkLocked(clkLocked),
  .streamReady(streamReady), .blockBytes(blockBytes),
  .hostRdStrobe(hostRdStrobe), .hostData(hostData), .hostReady(hostReady)
);

// File: tb/egress_bridge_tb_top.sv
module egress_ref #(
  parameter int RATIO     = 2,
  parameter int DEPTH_HW  = 1024,
  parameter int MAX_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sValid,
  input  logic [31:0] sData,
  input  logic        strobe,
  input  logic [15:0] bytes,
  output logic        expSReady,
  output logic        expHReady,
  output logic [15:0] expData
);
  int q[$];
  int qn = 0;
  int rem = 0;
  bit inBurst = 0;
  int bw;

  always_comb begin
    bw = ((int'(bytes) > MAX_BYTES) ? MAX_BYTES : int'(bytes)) / 2;
  end
  assign expSReady = (qn <= DEPTH_HW - RATIO);
  assign expHReady = !inBurst && bw != 0 && qn >= bw;

  initial expData = 16'h0;

  always @(posedge clk) begin
    bit sr, hr;
    sr = expSReady;
    hr = expHReady;
    if (rst) begin
      q.delete();
      inBurst = 0;
      rem = 0;
      expData = 16'h0;
    end else begin
      if (strobe && (inBurst || hr)) begin
        expData = 16'(q.pop_front());
        if (!inBurst) rem = bw - 1;
        else rem = rem - 1;
        inBurst = (rem > 0);
      end
      if (sValid && sr) begin
        if (RATIO == 2) begin
          q.push_back(int'(sData[31:16]));
          q.push_back(int'(sData[15:0]));
        end else begin
          q.push_back(int'(sData[15:0]));
        end
      end
    end
    qn = q.size();
  end
endmodule

module egress_bridge_tb_top;
  logic        clk = 0;
  logic        trig = 1, locked = 0;
  logic        sValid = 0, strobe = 0;
  logic [31:0] sData = 0;
  logic [15:0] bytes = 0;
  logic        rst;
  int checks = 0, errors = 0;
  bit cmpEn = 0, done = 0;
  string phase = "start";

  always #4 clk = ~clk;
  assign rst = trig | ~locked;

  logic        srA, hrA, srB, hrB, esrA, ehrA, esrB, ehrB;
  logic [15:0] hdA, hdB, edA, edB;

  egress_bridge #(.STREAM_W(32)) dut_i (
    .clk(clk), .hostTrig(trig), .clkLocked(locked), .streamData(sData),
    .streamValid(sValid), .streamReady(srA), .blockBytes(bytes),
    .hostRdStrobe(strobe), .hostData(hdA), .hostReady(hrA));

  egress_bridge #(.STREAM_W(16)) dut16_i (
    .clk(clk), .hostTrig(trig), .clkLocked(locked), .streamData(sData[15:0]),
    .streamValid(sValid), .streamReady(srB), .blockBytes(bytes),
    .hostRdStrobe(strobe), .hostData(hdB), .hostReady(hrB));

  egress_ref #(.RATIO(2)) refA (.clk(clk), .rst(rst), .sValid(sValid), .sData(sData),
    .strobe(strobe), .bytes(bytes), .expSReady(esrA), .expHReady(ehrA), .expData(edA));
  egress_ref #(.RATIO(1)) refB (.clk(clk), .rst(rst), .sValid(sValid), .sData(sData),
    .strobe(strobe), .bytes(bytes), .expSReady(esrB), .expHReady(ehrB), .expData(edB));

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s [%s] act=%h exp=%h t=%0t", req, what, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpEn) begin
      chk("R2", "sReady32", 16'(srA), 16'(esrA));
      chk("R3 R4 R5 R9", "hReady32", 16'(hrA), 16'(ehrA));
      chk("R6 R7 R8", "data32", hdA, edA);
      chk("R2", "sReady16", 16'(srB), 16'(esrB));
      chk("R3 R4 R5 R9", "hReady16", 16'(hrB), 16'(ehrB));
      chk("R6 R8", "data16", hdB, edB);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) tick(); endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin
      sValid = 1; sData = $urandom; tick();
    end
    sValid = 0;
  endtask

  task automatic reads(int n);
    for (int i = 0; i < n; i++) begin strobe = 1; tick(); end
    strobe = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1 reset state
    phase = "R1 reset";
    ticks(3);
    @(negedge clk);
    chk("R1", "hReady in reset", 16'(hrA), 16'h0);
    chk("R1", "sReady in reset", 16'(srA), 16'h1);
    tick();
    trig = 1; locked = 1; tick(); trig = 0;
    @(negedge clk);
    chk("R1", "hReady after", 16'(hrA), 16'h0);
    chk("R1", "sReady after", 16'(srA), 16'h1);
    chk("R1", "data after", hdA, 16'h0);
    tick();
    cmpEn = 1;

    // R7 lane order
    phase = "R7 order";
    bytes = 16'd2;
    sValid = 1; sData = 32'h1234_ABCD; tick(); sValid = 0;
    ticks(1);
    strobe = 1; tick(); strobe = 0;
    @(negedge clk);
    chk("R7", "upper first", hdA, 16'h1234);
    chk("R6", "16-bit word", hdB, 16'hABCD);
    tick();
    strobe = 1; tick(); strobe = 0;
    @(negedge clk);
    chk("R7", "lower second", hdA, 16'hABCD);
    tick();

    // R3 zero-length block never ready
    phase = "R3 zero";
    bytes = 16'd0; push(6); ticks(2);
    @(negedge clk);
    chk("R3", "zero bytes", 16'(hrA), 16'h0);
    bytes = 16'd1; ticks(2);
    @(negedge clk);
    chk("R3", "one byte", 16'(hrA), 16'h0);
    tick();

    // R8 strobes ignored when not ready
    phase = "R8 ignore";
    bytes = 16'd200; reads(5); ticks(2);

    // R5 block reads with gaps
    phase = "R5 blocks";
    bytes = 16'd8;
    for (int k = 0; k < 6; k++) begin reads(3); ticks(2); push(2); end
    reads(20); ticks(3);

    // R9 change length mid-block
    phase = "R9 midchange";
    push(10); bytes = 16'd16; strobe = 1; tick(); tick();
    bytes = 16'd2; reads(10); ticks(3);

    // R4 clamp above maximum
    phase = "R4 clamp";
    bytes = 16'd4000; push(300); ticks(2);
    @(negedge clk);
    chk("R4", "512-word block ready", 16'(hrA), 16'h1);
    tick();
    reads(520); ticks(3);

    // R2 full boundary
    phase = "R2 full";
    bytes = 16'd0; push(1100); ticks(2);
    @(negedge clk);
    chk("R2", "full32", 16'(srA), 16'h0);
    chk("R2", "full16", 16'(srB), 16'h0);
    tick();
    bytes = 16'd1024; reads(600); push(40); ticks(3);

    // mid-run reset through lock loss
    phase = "R1 lock loss";
    locked = 0; tick(); locked = 1;
    @(negedge clk);
    chk("R1", "data cleared", hdA, 16'h0);
    chk("R1", "sReady cleared", 16'(srA), 16'h1);
    tick();

    // mixed traffic
    phase = "mixed";
    for (int i = 0; i < 4000; i++) begin
      sValid = ($urandom % 3) != 0;
      sData  = $urandom;
      strobe = ($urandom % 2) != 0;
      if ($urandom % 64 == 0) begin
        case ($urandom % 7)
          0: bytes = 16'd0;
          1: bytes = 16'd1;
          2: bytes = 16'd2;
          3: bytes = 16'd6;
          4: bytes = 16'd64;
          5: bytes = 16'd1024;
          default: bytes = 16'd3000;
        endcase
      end
      tick();
    end
    sValid = 0; strobe = 0;
    ticks(4);
    summary();
  end
endmodule